// File: doc/BRIEF.md
# Byte Queue with Level and Overflow Interrupts

This block is a synchronous byte queue for a serial bus controller. One instance holds command bytes that wait for the bus engine, and another holds bytes received from the bus. Bytes enter through a valid/ready stream and leave through a second valid/ready stream. The block reports its occupancy and a full flag. It also raises two latched interrupts: a level interrupt when the occupancy climbs to a programmable threshold, and an overflow interrupt when a byte arrives that cannot be stored.

Back-pressure works as follows. `in_ready` is high when a slot is free, or when the queue is full and the consumer takes a byte in the same cycle. A producer should hold `in_valid` until it sees `in_ready`. A producer that ignores `in_ready` loses the offered byte, and the overflow interrupt records the loss. On the output side, a byte leaves when `out_valid` and `out_ready` are both high. `out_ready` may be asserted while the queue is empty, and has no effect then.

Software can empty the queue at any time with a one-cycle flush strobe. It clears each interrupt with a per-bit clear strobe and gates each interrupt output with a per-bit enable. In the interrupt vectors, bit 0 is the level interrupt and bit 1 is the overflow interrupt.

Top module: `wmq_top`

## Requirements
- R1: While `rst_n` is low and at the first edge after its release, `occupancy` is 0, `out_valid` and `full` are low, `out_data` is 0 and both `irq_out` bits are 0.
- R2: Bytes leave in the order they were accepted. `out_valid` is high exactly when `occupancy` is nonzero, and `out_data` then shows the oldest stored byte.
- R3: `occupancy` equals the accepted writes minus the accepted reads since the last reset or flush. It changes at the clock edge of the transfer and never exceeds DEPTH.
- R4: `full` is high exactly when `occupancy` equals DEPTH, and `in_ready` equals `!full || out_ready`.
- R5: A byte offered while the queue is full and no read is taken is dropped. The occupancy and the stored bytes are unchanged.
- R6: The overflow latch (bit 1) is set at the edge of a dropped write that is not in a flush cycle. It holds until a cycle with `irq_clear[1]` high and no new overflow, so a set and a clear in the same cycle leave it set.
- R7: A write and a read in the same cycle while full are both taken, with no overflow, and the occupancy stays at DEPTH.
- R8: The level latch (bit 0) is set at an edge where the occupancy goes from below `wm_level` to at least `wm_level`. A level of 0, or a level above DEPTH, never sets it.
- R9: The level latch holds until a cycle with `irq_clear[0]` high and no new crossing, even if the occupancy falls back. It sets again only on a later upward crossing.
- R10: `sw_flush` empties the queue at the next edge. A write or read offered in the flush cycle is ignored, none of the discarded bytes ever appears on `out_data`, and the flush raises no interrupt.
- R11: `irq_out[i]` equals latch `i` AND `irq_enable[i]`. The latches keep running while their enable is low, so an event taken while disabled shows once the enable is set.
- R12: `out_data` is 0 whenever `out_valid` is low, including right after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write stream valid |
| in_ready | output | 1 | Write stream ready |
| in_data | input | DW | Write stream byte |
| out_valid | output | 1 | Read stream valid |
| out_ready | input | 1 | Read stream ready (pop) |
| out_data | output | DW | Oldest byte, 0 when empty |
| wm_level | input | CNT_W | Level interrupt threshold |
| sw_flush | input | 1 | Software queue reset strobe |
| irq_clear | input | 2 | Latch clear strobes (bit0 level, bit1 overflow) |
| irq_enable | input | 2 | Interrupt output enables |
| irq_out | output | 2 | Gated interrupts |
| full | output | 1 | Queue full status |
| occupancy | output | CNT_W | Stored byte count |

## Verification
The bench builds the queue with DEPTH 4 and 8-bit data, so the 3-bit threshold can take every value from 0 to 7. That range covers the disabled level 0, each reachable level, and levels above the depth. For every level, the bench fills the queue to full and past it, runs reads and writes together at full, drains to empty, flushes with data pending, and sets and clears the latches in the same cycle. The enable pattern changes with each level, so each of the four enable combinations meets a real event.

// File: rtl/wmq_pkg.sv
package wmq_pkg;
  localparam int IRQ_LVL = 0;
  localparam int IRQ_OVF = 1;
  localparam int IRQ_N   = 2;

  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/wmq_store.sv
module wmq_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    slot_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= bump(wptr_q);
      if (pop)  rptr_q <= bump(rptr_q);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !flush && wptr_q == PTR_W'(i)) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[rptr_q];
endmodule

// File: rtl/wmq_count.sv
module wmq_count #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             is_full,
  output logic             is_empty
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_next = cnt_q;
    if (flush) cnt_next = '0;
    else if (push && !pop) cnt_next = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_next = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  assign cnt      = cnt_q;
  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign is_empty = (cnt_q == '0);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)
                       || cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
endmodule

// File: rtl/wmq_irq.sv
module wmq_irq
  import wmq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] level,
  input  logic             drop,
  input  irq_vec_t         clr,
  input  irq_vec_t         en,
  output irq_vec_t         irq
);
  irq_vec_t ev, lat;

  assign ev[IRQ_LVL] = (cnt < level) && (cnt_next >= level);
  assign ev[IRQ_OVF] = drop;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_latch
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ev[g] | (q & ~clr[g]);
    end
    assign lat[g] = q;
    assign irq[g] = q & en[g];

    // R6 R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr[g]) |=> q);

    // R6 R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[g] && clr[g]) |=> q);
  end

  // R8
  level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !lat[IRQ_LVL]) |=> !lat[IRQ_LVL]);
endmodule

// File: rtl/wmq_top.sv
module wmq_top
  import wmq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  input  logic [CNT_W-1:0] wm_level,
  input  logic             sw_flush,
  input  logic [1:0]       irq_clear,
  input  logic [1:0]       irq_enable,
  output logic [1:0]       irq_out,
  output logic             full,
  output logic [CNT_W-1:0] occupancy
);
  logic             push, pop, drop, empty;
  logic [CNT_W-1:0] cnt, cnt_next;
  logic [DW-1:0]    head;

  assign out_valid = !empty;
  assign in_ready  = !full || out_ready;
  assign pop       = out_valid && out_ready && !sw_flush;
  assign push      = in_valid && in_ready && !sw_flush;
  assign drop      = in_valid && !in_ready && !sw_flush;
  assign out_data  = out_valid ? head : '0;
  assign occupancy = cnt;

  wmq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(sw_flush),
    .wdata(in_data), .rdata(head)
  );

  wmq_count #(.DEPTH(DEPTH)) u_count (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(sw_flush),
    .cnt(cnt), .cnt_next(cnt_next), .is_full(full), .is_empty(empty)
  );

  wmq_irq #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_next(cnt_next), .level(wm_level),
    .drop(drop), .clr(irq_clear), .en(irq_enable), .irq(irq_out)
  );

  // R5
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready && !sw_flush) |=> full);

  // R7
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && out_ready && !sw_flush) |=> (full && !$rose(u_irq.lat[IRQ_OVF])));
endmodule

// File: tb/wmq_top_test.sv
module wmq_top_test;
  localparam int D  = 4;
  localparam int DW = 8;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, sw_flush = 0;
  logic [DW-1:0] in_data = 0;
  logic [CW-1:0] wm_level = 0;
  logic [1:0] irq_clear = 0, irq_enable = 0;
  logic in_ready, out_valid, full;
  logic [DW-1:0] out_data;
  logic [1:0] irq_out;
  logic [CW-1:0] occupancy;

  int checks = 0, fails = 0, seq = 0, lvl_m = 0;
  int q[$];
  bit wm_m = 0, ovf_m = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wmq_top #(.DEPTH(D), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .wm_level(wm_level), .sw_flush(sw_flush),
    .irq_clear(irq_clear), .irq_enable(irq_enable), .irq_out(irq_out),
    .full(full), .occupancy(occupancy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic post_check();
    int n = q.size();
    int hd = (n > 0) ? q[0] : 0;
    chk(occupancy == CW'(n), "R3 occupancy", occupancy, n);
    chk(full == (n == D), "R4 full", full, n == D);
    chk(out_valid == (n > 0), "R2 out_valid", out_valid, n > 0);
    chk(out_data == DW'(hd), "R2/R12 out_data", out_data, hd);
    chk(irq_out[0] == (wm_m & irq_enable[0]), "R8/R9/R11 level irq", irq_out[0], wm_m & irq_enable[0]);
    chk(irq_out[1] == (ovf_m & irq_enable[1]), "R5/R6/R11 overflow irq", irq_out[1], ovf_m & irq_enable[1]);
  endtask

  // one cycle with model update; inputs driven at negedge
  task automatic cyc(input bit v, input bit r, input bit fl, input logic [1:0] clr);
    int n0, n1;
    bit rdy, pu, po, dr, wev;
    int b = (seq * 37 + 11) & 8'hff;
    in_valid = v; out_ready = r; sw_flush = fl; irq_clear = clr; in_data = DW'(b);
    #1;
    n0 = q.size();
    rdy = (n0 != D) || r;
    chk(in_ready == rdy, "R4 in_ready", in_ready, rdy);
    po = (n0 > 0) && r && !fl;
    pu = v && rdy && !fl;
    dr = v && !rdy && !fl;
    if (fl) q.delete();
    else begin
      if (po) void'(q.pop_front());
      if (pu) begin q.push_back(b); seq++; end
    end
    n1 = q.size();
    wev = (n0 < lvl_m) && (n1 >= lvl_m);
    wm_m  = wev | (wm_m & !clr[0]);
    ovf_m = dr | (ovf_m & !clr[1]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; out_ready = 0; sw_flush = 0; irq_clear = 0;
    post_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(occupancy == 0 && !out_valid && !full && out_data == 0 && irq_out == 0,
        "R1 reset state", {occupancy, out_valid, full}, 0);
    rst_n = 1;
    @(negedge clk);
    irq_enable = 2'b11;
    post_check();

    for (int lvl = 0; lvl < 8; lvl++) begin
      wm_level = CW'(lvl);
      lvl_m = lvl;
      irq_enable = 2'(lvl);
      cyc(1, 0, 1, 2'b00);                     // R10 flush beats push
      cyc(0, 0, 0, 2'b11);
      for (int k = 0; k < D + 2; k++) cyc(1, 0, 0, 2'b00);  // R5 R6 R8 fill past full
      for (int k = 0; k < 3; k++) cyc(1, 1, 0, 2'b00);      // R7 push+pop at full
      for (int k = 0; k < D; k++) cyc(0, 1, 0, 2'b00);      // R2 drain, R9 hold
      cyc(0, 1, 0, 2'b00);                                  // pop on empty
      irq_enable = 2'b11;
      cyc(0, 0, 0, 2'b00);                                  // R11 latched while disabled
      for (int k = 0; k < D; k++) cyc(1, 0, 0, 2'b11);      // set wins over clear
      cyc(1, 0, 0, 2'b11);                                  // R6 overflow with clear
      cyc(0, 0, 0, 2'b11);                                  // clears
      for (int k = 0; k < 2; k++) cyc(0, 1, 0, 2'b00);
      cyc(1, 1, 1, 2'b00);                                  // R10 flush with data, R12
      for (int k = 0; k < D; k++) cyc(1, (k % 2) == 1, 0, 2'b00); // R9 recross
      cyc(0, 0, 1, 2'b00);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule